// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table held in memory. A client gives it a virtual address, an access mode (user or privileged) and a direction (read or write), together with the base address of the first-level table. The walker fetches the first-level descriptor, follows it to a coarse second-level table, and fetches the small-page descriptor there. It then returns either the physical address with the page's bufferable and cacheable bits, or a fault code.

Memory is reached through a single read port that allows one read at a time. The port has a valid/ready request channel and a response that is marked by a data-valid strobe. The response may come any number of cycles after the request is accepted, with a minimum of one. Only one walk is in flight. A new request is taken only while the walker is idle, and every result stays on the outputs until the next result replaces it.

Top module: `pgwalk`

## Requirements
- R1: After reset, reqReady is 1, done is 0 and memReqValid is 0.
- R2: The first read goes to address {tableBase[31:14], reqVaddr[31:20], 2'b00}. Bits [13:0] of tableBase are ignored.
- R3: If bits [1:0] of the first-level descriptor are 01, the walk continues. Any other value (00, 10 or 11) ends the walk after that single read, with faultKind = 1, physAddr = 0 and both attribute bits 0.
- R4: The second read goes to address {l1desc[31:10], va[19:12], 2'b00}.
- R5: If bits [1:0] of the second-level descriptor are 10 and the permission check passes, the result is faultKind = 0 and physAddr = {l2desc[31:12], va[11:0]}. Any other type code (00, 01 or 11) gives faultKind = 2 and physAddr = 0.
- R6: The permission code is l2desc[5+2q:4+2q], where q = va[11:10]. Code 0 allows nothing. Code 1 allows privileged read and write, and no user access. Code 2 allows privileged read and write, and user read. Code 3 allows everything. An access that is not allowed gives faultKind = 3 and physAddr = 0.
- R7: On success, attrBuf equals l2desc[2] and attrCache equals l2desc[3]. On any fault, both are 0.
- R8: memReqValid stays high with a stable memReqAddr until memReqReady is seen. Responses with a latency of one or more cycles are all handled.
- R9: done is a one-cycle pulse. physAddr, faultKind and the attribute bits change only in the cycle that done rises, and stay the same until the next done.
- R10: reqReady is low from the moment a request is accepted until its done. A reqValid seen while reqReady is low is ignored: it causes no memory read and no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request strobe |
| reqReady | output | 1 | Walker idle, request will be taken |
| reqVaddr | input | 32 | Virtual address to translate |
| reqUser | input | 1 | 1 = user mode, 0 = privileged |
| reqWrite | input | 1 | 1 = write access, 0 = read |
| tableBase | input | 32 | First-level table base (16 KB aligned) |
| memReqValid | output | 1 | Descriptor read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 32 | Descriptor word address |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Descriptor read data |
| done | output | 1 | One-cycle completion pulse |
| faultKind | output | 2 | 0 none, 1 level-1 translation, 2 level-2 translation, 3 permission |
| physAddr | output | 32 | Translated address (0 on fault) |
| attrBuf | output | 1 | Bufferable bit of the page |
| attrCache | output | 1 | Cacheable bit of the page |

## Verification
Some rules are checked by assertions on every cycle: the read request is held until it is accepted, at most one control strobe fires at a time, done lasts a single cycle and comes only while the walker is idle, no read is issued while the walker is idle, and the outputs change only in a cycle that follows a memory response. Other outcomes can only be shown by the bench's scenarios. These are the exact descriptor addresses, the meaning of each type code at both levels, the choice of permission field by quarter together with the full mode and direction table, the attribute bits, the number of reads a walk makes, and the fact that requests arriving while the walker is busy are ignored. The bench covers these with a memory model whose latency and ready signal vary.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  typedef enum logic [1:0] {
    FK_NONE = 2'd0,
    FK_L1   = 2'd1,
    FK_L2   = 2'd2,
    FK_PERM = 2'd3
  } faultKind_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_L1REQ = 3'd1,
    ST_L1RSP = 3'd2,
    ST_L2REQ = 3'd3,
    ST_L2RSP = 3'd4
  } walkState_e;

  typedef struct packed {
    logic takeReq;  // capture request, form first-level address
    logic takeL1;   // capture coarse base, form second-level address
    logic endL1;    // finish with first-level fault
    logic endL2;    // finish after second-level descriptor
  } walkStrobe_t;

endpackage

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        l1Ok,
  output logic        reqReady,
  output logic        memReqValid,
  output walkStrobe_t strobe
);

  walkState_e st, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    nxt    = st;
    strobe = '0;
    case (st)
      ST_IDLE: if (reqValid) begin
        strobe.takeReq = 1'b1;
        nxt = ST_L1REQ;
      end
      ST_L1REQ: if (memReqReady) nxt = ST_L1RSP;
      ST_L1RSP: if (memRspValid) begin
        if (l1Ok) begin
          strobe.takeL1 = 1'b1;
          nxt = ST_L2REQ;
        end else begin
          strobe.endL1 = 1'b1;
          nxt = ST_IDLE;
        end
      end
      ST_L2REQ: if (memReqReady) nxt = ST_L2RSP;
      ST_L2RSP: if (memRspValid) begin
        strobe.endL2 = 1'b1;
        nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign reqReady    = (st == ST_IDLE);
  assign memReqValid = (st == ST_L1REQ) || (st == ST_L2REQ);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid);

  // R10
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  // R9
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

endmodule

// File: rtl/pgwalk_dpath.sv
module pgwalk_dpath
  import pgwalk_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int L1_BITS   = 12,
  parameter int L2_BITS   = 8,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic              reqUser,
  input  logic              reqWrite,
  input  logic [VA_W-1:0]   tableBase,
  input  logic [VA_W-1:0]   memRspData,
  output logic [VA_W-1:0]   walkAddr,
  output logic              l1Ok,
  output logic              done,
  output logic [1:0]        faultKind,
  output logic [VA_W-1:0]   physAddr,
  output logic              attrBuf,
  output logic              attrCache
);

  localparam int L1_ALIGN   = L1_BITS + 2;
  localparam int COARSE_LSB = L2_BITS + 2;
  localparam int LOW_W      = PAGE_BITS + L2_BITS;
  localparam int PERM_LSB   = 4;

  logic [LOW_W-1:0] vaLow;
  logic             userR, writeR;
  logic             l2Ok, permOk;
  logic [1:0]       quarter, permCode;
  logic [7:0]       permField;
  logic             unusedBase;

  assign unusedBase = ^tableBase[L1_ALIGN-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaLow    <= '0;
      userR    <= 1'b0;
      writeR   <= 1'b0;
      walkAddr <= '0;
    end else if (strobe.takeReq) begin
      vaLow    <= reqVaddr[LOW_W-1:0];
      userR    <= reqUser;
      writeR   <= reqWrite;
      walkAddr <= {tableBase[VA_W-1:L1_ALIGN], reqVaddr[VA_W-1 -: L1_BITS], 2'b00};
    end else if (strobe.takeL1) begin
      walkAddr <= {memRspData[VA_W-1:COARSE_LSB], vaLow[LOW_W-1:PAGE_BITS], 2'b00};
    end
  end

  assign l1Ok      = (memRspData[1:0] == 2'b01);
  assign l2Ok      = (memRspData[1:0] == 2'b10);
  assign quarter   = vaLow[PAGE_BITS-1 -: 2];
  assign permField = memRspData[PERM_LSB +: 8];
  assign permCode  = permField[2*quarter +: 2];

  always_comb begin
    case (permCode)
      2'd0:    permOk = 1'b0;
      2'd1:    permOk = !userR;
      2'd2:    permOk = !userR || !writeR;
      default: permOk = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done      <= 1'b0;
      faultKind <= FK_NONE;
      physAddr  <= '0;
      attrBuf   <= 1'b0;
      attrCache <= 1'b0;
    end else begin
      done <= strobe.endL1 || strobe.endL2;
      if (strobe.endL1) begin
        faultKind <= FK_L1;
        physAddr  <= '0;
        attrBuf   <= 1'b0;
        attrCache <= 1'b0;
      end else if (strobe.endL2) begin
        if (l2Ok && permOk) begin
          faultKind <= FK_NONE;
          physAddr  <= {memRspData[VA_W-1:PAGE_BITS], vaLow[PAGE_BITS-1:0]};
          attrBuf   <= memRspData[2];
          attrCache <= memRspData[3];
        end else begin
          faultKind <= l2Ok ? FK_PERM : FK_L2;
          physAddr  <= '0;
          attrBuf   <= 1'b0;
          attrCache <= 1'b0;
        end
      end
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/pgwalk.sv
module pgwalk
  import pgwalk_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int L1_BITS   = 12,
  parameter int L2_BITS   = 8,
  parameter int PAGE_BITS = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic [VA_W-1:0] reqVaddr,
  input  logic            reqUser,
  input  logic            reqWrite,
  input  logic [VA_W-1:0] tableBase,
  output logic            memReqValid,
  input  logic            memReqReady,
  output logic [VA_W-1:0] memReqAddr,
  input  logic            memRspValid,
  input  logic [VA_W-1:0] memRspData,
  output logic            done,
  output logic [1:0]      faultKind,
  output logic [VA_W-1:0] physAddr,
  output logic            attrBuf,
  output logic            attrCache
);

  walkStrobe_t strobe;
  logic        l1Ok;

  pgwalk_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .l1Ok        (l1Ok),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .strobe      (strobe)
  );

  pgwalk_dpath #(
    .VA_W      (VA_W),
    .L1_BITS   (L1_BITS),
    .L2_BITS   (L2_BITS),
    .PAGE_BITS (PAGE_BITS)
  ) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqVaddr   (reqVaddr),
    .reqUser    (reqUser),
    .reqWrite   (reqWrite),
    .tableBase  (tableBase),
    .memRspData (memRspData),
    .walkAddr   (memReqAddr),
    .l1Ok       (l1Ok),
    .done       (done),
    .faultKind  (faultKind),
    .physAddr   (physAddr),
    .attrBuf    (attrBuf),
    .attrCache  (attrCache)
  );

  // R8
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memReqAddr));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memRspValid |=> $stable(physAddr) && $stable(faultKind));

  // R10
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> reqReady);

  // R10
  no_read_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady);

endmodule

// File: tb/tb_pgwalk.sv
`timescale 1ns/100ps
module tb_pgwalk;

  typedef struct {
    logic [31:0] a1, a2, pa;
    logic [1:0]  kind;
    logic        buff, cache;
    int          nReads;
  } expItem_t;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        reqValid = 1'b0, reqUser = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqVaddr = '0, tableBase = '0;
  logic        memReqReady = 1'b0, memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        reqReady, memReqValid, done, attrBuf, attrCache;
  logic [31:0] memReqAddr, physAddr;
  logic [1:0]  faultKind;

  int checks = 0, errors = 0, doneCount = 0, issued = 0;
  logic [31:0] mem [logic [31:0]];
  expItem_t    sbQ [$];
  logic [31:0] actAddr [2];
  int          actN = 0;
  logic [7:0]  lfsr = 8'hA5;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  pgwalk dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .reqUser(reqUser), .reqWrite(reqWrite),
    .tableBase(tableBase), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .done(done), .faultKind(faultKind), .physAddr(physAddr),
    .attrBuf(attrBuf), .attrCache(attrCache)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic expItem_t predict(logic [31:0] va, logic user, logic wr, logic [31:0] base);
    expItem_t e;
    logic [31:0] d1, d2;
    logic [1:0]  ap;
    logic        ok;
    e.a1 = {base[31:14], va[31:20], 2'b00};
    e.a2 = 32'h0; e.pa = 32'h0; e.buff = 1'b0; e.cache = 1'b0;
    d1 = rd(e.a1);
    e.nReads = 1;
    if (d1[1:0] != 2'b01) begin
      e.kind = 2'd1;
      return e;
    end
    e.a2 = {d1[31:10], va[19:12], 2'b00};
    d2 = rd(e.a2);
    e.nReads = 2;
    if (d2[1:0] != 2'b10) begin
      e.kind = 2'd2;
      return e;
    end
    ap = d2[4 + 2*va[11:10] +: 2];
    ok = (ap == 2'd3) || (ap == 2'd1 && !user) || (ap == 2'd2 && (!user || !wr));
    if (!ok) begin
      e.kind = 2'd3;
      return e;
    end
    e.kind = 2'd0;
    e.pa = {d2[31:12], va[11:0]};
    e.buff = d2[2];
    e.cache = d2[3];
    return e;
  endfunction

  task automatic setL1(logic [31:0] base, logic [11:0] idx, logic [31:0] d);
    mem[{base[31:14], idx, 2'b00}] = d;
  endtask

  task automatic setL2(logic [31:0] tbl, logic [7:0] idx, logic [31:0] d);
    mem[{tbl[31:10], idx, 2'b00}] = d;
  endtask

  function automatic logic [31:0] pageDesc(logic [19:0] frame, logic [7:0] perms, logic c, logic b);
    return {frame, perms, c, b, 2'b10};
  endfunction

  // Driver: pushes expected item, issues request, optionally pokes junk while busy
  task automatic doWalk(logic [31:0] va, logic user, logic wr, logic [31:0] base, bit junk);
    do @(negedge clk); while (!reqReady);
    sbQ.push_back(predict(va, user, wr, base));
    actN = 0;
    reqVaddr = va; reqUser = user; reqWrite = wr; tableBase = base;
    reqValid = 1'b1;
    issued++;
    @(negedge clk);
    if (junk) begin
      reqVaddr = 32'h2000_0000; // R10: would fault with one read if taken
      @(negedge clk);
      @(negedge clk);
    end
    reqValid = 1'b0;
    while (doneCount != issued) @(negedge clk);
    @(negedge clk);
  endtask

  // Memory model with varying ready and latency
  initial begin
    logic [31:0] pendAddr;
    int lat;
    bit busy;
    busy = 0; lat = 0; pendAddr = '0;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      memRspValid = 1'b0;
      if (busy) begin
        if (lat == 0) begin
          memRspValid = 1'b1;
          memRspData = rd(pendAddr);
          busy = 0;
        end else lat--;
      end
      memReqReady = !busy && (lfsr[0] || lfsr[1]);
      if (memReqValid && memReqReady) begin
        if (actN < 2) actAddr[actN] = memReqAddr;
        actN++;
        pendAddr = memReqAddr;
        busy = 1;
        lat = int'(lfsr[3:2]);
      end
    end
  end

  // Monitor: pops expected item on each done and compares
  initial begin
    expItem_t e;
    logic [31:0] holdPa;
    logic [1:0]  holdKind;
    string tag;
    forever begin
      @(negedge clk);
      if (rstN && done) begin
        doneCount++;
        if (sbQ.size() == 0) begin
          check("R10 spurious done", 32'd1, 32'd0);
        end else begin
          e = sbQ.pop_front();
          tag = (e.kind == 2'd1) ? "R3" : (e.kind == 2'd3) ? "R6" : "R5";
          check({tag, " faultKind"}, {30'd0, faultKind}, {30'd0, e.kind});
          check({tag, " physAddr"}, physAddr, e.pa);
          check("R7 attrBuf", {31'd0, attrBuf}, {31'd0, e.buff});
          check("R7 attrCache", {31'd0, attrCache}, {31'd0, e.cache});
          check("R3 read count", actN, e.nReads);
          if (actN >= 1) check("R2 first address", actAddr[0], e.a1);
          if (e.nReads == 2 && actN >= 2) check("R4 second address", actAddr[1], e.a2);
        end
        holdPa = physAddr; holdKind = faultKind;
        @(negedge clk);
        check("R9 done pulse", {31'd0, done}, 32'd0);
        check("R9 hold physAddr", physAddr, holdPa);
        check("R9 hold faultKind", {30'd0, faultKind}, {30'd0, holdKind});
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [31:0] BASE0 = 32'h0004_0000;
  localparam logic [31:0] BASE1 = 32'h0FFF_C000;
  localparam logic [31:0] TBL1  = 32'h0010_0400;
  localparam logic [31:0] TBL2  = 32'h0020_0000;

  initial begin
    setL1(BASE0, 12'h123, 32'h0010_05E1);
    setL2(TBL1, 8'h45, pageDesc(20'hABCDE, 8'hAA, 1'b0, 1'b1));
    setL2(TBL1, 8'h46, pageDesc(20'h13579, 8'hE4, 1'b1, 1'b0));
    setL2(TBL1, 8'h47, 32'hFFFF_FFFC);
    setL2(TBL1, 8'h48, 32'h1234_5671);
    setL2(TBL1, 8'h49, 32'h0000_0FF3);
    setL2(TBL1, 8'h4A, pageDesc(20'hFFFFF, 8'hFF, 1'b1, 1'b1));
    setL1(BASE0, 12'h201, 32'h0010_0402);
    setL1(BASE0, 12'h202, 32'h0010_0403);
    setL1(BASE1, 12'h123, 32'h0020_0001);
    setL2(TBL2, 8'h4A, pageDesc(20'h00042, 8'h00, 1'b0, 1'b0));

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check("R1 reqReady", {31'd0, reqReady}, 32'd1);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 memReqValid", {31'd0, memReqValid}, 32'd0);

    doWalk(32'h1234_5ABC, 1'b1, 1'b0, BASE0, 1'b1);       // R5 R7 user read on code 2, junk R10
    doWalk(32'h1234_5ABC, 1'b1, 1'b1, BASE0, 1'b0);       // R6 user write on code 2
    doWalk(32'h1234_5ABC, 1'b0, 1'b1, BASE0 | 32'h3FFF, 1'b0); // R2 low base bits ignored
    doWalk(32'h1234_60F0, 1'b0, 1'b0, BASE0, 1'b0);       // R6 quarter 0 code 0
    doWalk(32'h1234_64F0, 1'b1, 1'b0, BASE0, 1'b0);       // R6 quarter 1 code 1 user
    doWalk(32'h1234_64F0, 1'b0, 1'b1, BASE0, 1'b0);       // R6 quarter 1 privileged write
    doWalk(32'h1234_68F0, 1'b1, 1'b0, BASE0, 1'b0);       // R6 quarter 2 user read
    doWalk(32'h1234_68F0, 1'b1, 1'b1, BASE0, 1'b0);       // R6 quarter 2 user write
    doWalk(32'h1234_6CF0, 1'b1, 1'b1, BASE0, 1'b0);       // R6 quarter 3 code 3
    doWalk(32'h1234_7000, 1'b0, 1'b0, BASE0, 1'b0);       // R5 type 00
    doWalk(32'h1234_8000, 1'b0, 1'b0, BASE0, 1'b0);       // R5 type 01
    doWalk(32'h1234_9000, 1'b0, 1'b0, BASE0, 1'b0);       // R5 type 11
    doWalk(32'h2000_0000, 1'b0, 1'b0, BASE0, 1'b1);       // R3 type 00, junk R10
    doWalk(32'h2010_0000, 1'b0, 1'b0, BASE0, 1'b0);       // R3 type 10
    doWalk(32'h2020_0000, 1'b0, 1'b0, BASE0, 1'b0);       // R3 type 11
    doWalk(32'h1234_A123, 1'b0, 1'b0, BASE1, 1'b0);       // R4 other base, code 0 fault
    doWalk(32'h1234_A123, 1'b1, 1'b1, BASE0, 1'b1);       // R7 both attributes, R8 latency mix

    repeat (10) @(negedge clk);
    check("R10 done count", doneCount, issued);
    check("R10 queue empty", sbQ.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule